// File: doc/BRIEF.md
# Stereo Transmit FIFO with Refill Interrupt

This block is a small stereo sample buffer between a processor write port and an audio serial transmitter. Each entry pairs a left and a right sample, 24 bits each by default, and the buffer holds four entries by default. Software pushes entry pairs. The transmitter pops one pair each time it needs a new stereo frame and reads the oldest pair combinationally from the head outputs.

Software does not poll a watermark. It picks one of three refill modes: one entry, half the depth, or the whole depth. The block counts how many entries the transmitter has really drained since the last request. When that count reaches the mode's target, it raises a level-sensitive refill flag, and software then writes exactly that many entries. The flag stays set until software acknowledges it, and it reaches the interrupt output only while the enable input is high.

Transmission is meant to begin with a full buffer, whatever mode is set. An occupancy count shows how many entries remain. A sticky underrun flag records any pop made while the buffer was empty.

Top module: `stereo_tx_fifo`

## Requirements
- R1: After reset the occupancy is 0, the interrupt output and the underrun flag are 0, and both head outputs read 0.
- R2: Entries leave in the order they were pushed. While the buffer is not empty, `tx_left` and `tx_right` show the oldest pair, and a pop advances to the next pair.
- R3: `level` is the number of stored entries (0 to DEPTH). An accepted push adds 1, an accepted pop subtracts 1, and both in the same cycle leave it unchanged.
- R4: A push while `level` equals DEPTH is ignored. The count stays at DEPTH and the stored pairs are unchanged.
- R5: A pop while the buffer is empty drives 0 on both head outputs before the edge. It leaves `level` at 0, sets `underrun` (which stays 1 until reset), and is not counted as a drained entry.
- R6: The mode register is written from `mode_wdata` when `mode_we` is 1, and it resets to 0 (half mode). Mode codes: 0 = half, 1 = whole, 2 = one, 3 = reserved.
- R7: In whole mode the flag sets on the edge that completes the DEPTH-th drained entry, and not before.
- R8: In one mode every drained entry sets the flag.
- R9: In half mode the flag sets when DEPTH/2 entries have drained since the last time the flag was set. The count then starts again from zero.
- R10: In reserved mode the flag never sets, however many entries drain.
- R11: `irq` equals the flag ANDed with `irq_en`. A flag set while the enable is low appears on `irq` as soon as `irq_en` goes high.
- R12: Once set, the flag holds until a cycle with `irq_ack` = 1 clears it. If a new hit and an acknowledge fall in the same cycle, the flag stays set.
- R13: `irq` rises in the cycle right after the clock edge that accepts the pop completing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push one stereo entry |
| wr_left | input | 24 (SAMPLE_W) | Left sample to push |
| wr_right | input | 24 (SAMPLE_W) | Right sample to push |
| tx_pop | input | 1 | Transmitter consumes the head entry |
| tx_left | output | 24 (SAMPLE_W) | Head left sample, 0 when empty |
| tx_right | output | 24 (SAMPLE_W) | Head right sample, 0 when empty |
| mode_we | input | 1 | Write strobe for the refill mode register |
| mode_wdata | input | 2 | New refill mode code |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the refill flag |
| irq | output | 1 | Refill interrupt request |
| level | output | 3 (LVL_W) | Number of stored entries |
| underrun | output | 1 | Sticky flag for a pop from an empty buffer |

## Verification
A drain counter that is off by one does not show as a wrong value right away. It shows as `irq` rising one pop early or late, so each mode test checks `irq` after every single pop, not only at the end. A pointer fault appears at the head outputs on the very next pop as a swapped or repeated pair. A miscounted occupancy shows on `level` in the cycle after the push or pop. A stray drain counted during an empty pop stays hidden until the next full drain in whole mode, where `irq` then rises after the third pop instead of the fourth.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    MODE_HALF  = 2'd0,
    MODE_WHOLE = 2'd1,
    MODE_ONE   = 2'd2,
    MODE_RSVD  = 2'd3
  } refill_mode_e;

  // Entries that must drain before a refill request; 0 means never.
  function automatic int unsigned drain_target(refill_mode_e m, int unsigned depth);
    case (m)
      MODE_HALF:  return depth / 2;
      MODE_WHOLE: return depth;
      MODE_ONE:   return 1;
      default:    return 0;
    endcase
  endfunction

  // Ring pointer advance for a depth that need not be a power of two.
  function automatic int unsigned ring_next(int unsigned ptr, int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/stx_store.sv
module stx_store #(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned SAMPLE_W = 24,
  localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [SAMPLE_W-1:0] push_l,
  input  logic [SAMPLE_W-1:0] push_r,
  input  logic                pop,
  output logic [SAMPLE_W-1:0] head_l,
  output logic [SAMPLE_W-1:0] head_r,
  output logic [LVL_W-1:0]    level,
  output logic                push_ok,
  output logic                pop_ok,
  output logic                pop_empty
);
  import stx_pkg::*;

  logic [SAMPLE_W-1:0] mem_l [DEPTH];
  logic [SAMPLE_W-1:0] mem_r [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic                is_empty, is_full;

  assign is_empty  = (level == '0);
  assign is_full   = (level == LVL_W'(DEPTH));
  assign push_ok   = push && !is_full;
  assign pop_ok    = pop && !is_empty;
  assign pop_empty = pop && is_empty;

  assign head_l = is_empty ? '0 : mem_l[rd_ptr];
  assign head_r = is_empty ? '0 : mem_r[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && wr_ptr == PTR_W'(i)) begin
        mem_l[i] <= push_l;
        mem_r[i] <= push_r;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R4
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && push && !pop) |=> (level == LVL_W'(DEPTH)));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && pop && !push) |=> (level == '0));

endmodule

// File: rtl/stx_refill_irq.sv
module stx_refill_irq #(
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  stx_pkg::refill_mode_e mode,
  input  logic                  drained,
  input  logic                  ack,
  output logic                  flag,
  output logic                  refill_hit
);
  import stx_pkg::*;

  logic [CNT_W-1:0] cnt, cnt_inc, target;

  assign target     = CNT_W'(drain_target(mode, DEPTH));
  assign cnt_inc    = cnt + 1'b1;
  assign refill_hit = drained && (target != '0) && (cnt_inc >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (refill_hit)                    cnt <= '0;
      else if (drained && target != '0) cnt <= cnt_inc;
      if (refill_hit)   flag <= 1'b1;
      else if (ack)     flag <= 1'b0;
    end
  end

  // R13
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_hit |=> flag);

  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack) |=> flag);

  // R10
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RSVD && !flag) |=> !flag);

  // R8
  one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ONE && drained) |=> flag);

endmodule

// File: rtl/stereo_tx_fifo.sv
module stereo_tx_fifo #(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned SAMPLE_W = 24,
  localparam int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_left,
  input  logic [SAMPLE_W-1:0] wr_right,
  input  logic                tx_pop,
  output logic [SAMPLE_W-1:0] tx_left,
  output logic [SAMPLE_W-1:0] tx_right,
  input  logic                mode_we,
  input  logic [1:0]          mode_wdata,
  input  logic                irq_en,
  input  logic                irq_ack,
  output logic                irq,
  output logic [LVL_W-1:0]    level,
  output logic                underrun
);
  import stx_pkg::*;

  refill_mode_e mode_q;
  logic         push_ok, pop_ok, pop_empty, refill_flag, refill_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_HALF;
      underrun <= 1'b0;
    end else begin
      if (mode_we)   mode_q   <= refill_mode_e'(mode_wdata);
      if (pop_empty) underrun <= 1'b1;
    end
  end

  stx_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_store (
    .clk, .rst_n,
    .push(wr_en), .push_l(wr_left), .push_r(wr_right),
    .pop(tx_pop), .head_l(tx_left), .head_r(tx_right),
    .level, .push_ok, .pop_ok, .pop_empty
  );

  stx_refill_irq #(.DEPTH(DEPTH)) u_irq (
    .clk, .rst_n, .mode(mode_q), .drained(pop_ok), .ack(irq_ack),
    .flag(refill_flag), .refill_hit
  );

  assign irq = refill_flag && irq_en;

  // R5
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R5
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> underrun);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R5
  no_count_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |-> !refill_hit);

endmodule

// File: tb/stereo_tx_fifo_bench.sv
module stereo_tx_fifo_bench;
  localparam int D = 4;
  localparam int W = 24;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, tx_pop = 0, mode_we = 0, irq_en = 0, irq_ack = 0;
  logic [W-1:0] wr_left = '0, wr_right = '0;
  logic [1:0] mode_wdata = '0;
  logic [W-1:0] tx_left, tx_right;
  logic irq, underrun;
  logic [2:0] level;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [2*W-1:0] model [$];
  int seed_ctr = 0;

  always #10 clk = ~clk;

  stereo_tx_fifo u_stereo_tx_fifo (
    .clk, .rst_n, .wr_en, .wr_left, .wr_right, .tx_pop, .tx_left, .tx_right,
    .mode_we, .mode_wdata, .irq_en, .irq_ack, .irq, .level, .underrun
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(logic [W-1:0] l, logic [W-1:0] r);
    @(negedge clk);
    wr_en = 1; wr_left = l; wr_right = r;
    @(negedge clk);
    wr_en = 0;
    if (model.size() < D) model.push_back({l, r});
  endtask

  task automatic fill();
    while (model.size() < D) begin
      seed_ctr++;
      push(W'(24'hA00000 + seed_ctr), W'(24'h500000 + seed_ctr * 3));
    end
    chk("R3 level full", 64'(level), 64'(D));
  endtask

  task automatic pop(string req, logic ack = 0);
    logic [2*W-1:0] exp;
    @(negedge clk);
    tx_pop = 1; irq_ack = ack;
    exp = (model.size() > 0) ? model[0] : '0;
    #1;
    chk({req, " head"}, 64'({tx_left, tx_right}), 64'(exp));
    @(negedge clk);
    tx_pop = 0; irq_ack = 0;
    if (model.size() > 0) void'(model.pop_front());
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk); mode_we = 1; mode_wdata = m;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 level", 64'(level), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 underrun", 64'(underrun), 0);
    chk("R1 head", 64'({tx_left, tx_right}), 0);
  endtask

  task automatic t_default_half();
    irq_en = 1;
    fill();
    pop("R2 half pop1");
    chk("R6 no irq after 1 pop", 64'(irq), 0);
    pop("R2 half pop2");
    chk("R13 R9 irq after 2 pops", 64'(irq), 1);
    chk("R3 level after 2 pops", 64'(level), 2);
    ack();
    chk("R12 ack clears", 64'(irq), 0);
    pop("R2 half pop3");
    chk("R9 count restarts", 64'(irq), 0);
    pop("R2 half pop4");
    chk("R9 second request", 64'(irq), 1);
    chk("R3 level empty", 64'(level), 0);
    ack();
  endtask

  task automatic t_full_whole();
    set_mode(2'd1);
    fill();
    push(24'hFFFFFF, 24'hEEEEEE);
    chk("R4 level stays full", 64'(level), 64'(D));
    for (int i = 0; i < D - 1; i++) begin
      pop("R4 R2 drain");
      chk("R7 no early irq", 64'(irq), 0);
    end
    pop("R4 R2 drain last");
    chk("R7 irq after whole drain", 64'(irq), 1);
    ack();
  endtask

  task automatic t_underrun();
    pop("R5 empty pop zeros");
    chk("R5 underrun set", 64'(underrun), 1);
    chk("R5 level stays 0", 64'(level), 0);
    chk("R5 no irq", 64'(irq), 0);
    fill();
    for (int i = 0; i < D - 1; i++) pop("R5 drain");
    chk("R5 empty pop not counted", 64'(irq), 0);
    pop("R5 drain last");
    chk("R7 irq on fourth", 64'(irq), 1);
    ack();
    chk("R5 underrun sticky", 64'(underrun), 1);
  endtask

  task automatic t_one();
    set_mode(2'd2);
    fill();
    pop("R8 pop");
    chk("R8 irq each pop", 64'(irq), 1);
    repeat (3) @(negedge clk);
    chk("R12 level held", 64'(irq), 1);
    ack();
    chk("R12 cleared", 64'(irq), 0);
    pop("R8 pop2");
    chk("R8 irq again", 64'(irq), 1);
    pop("R12 pop with ack", 1'b1);
    chk("R12 set wins over ack", 64'(irq), 1);
    ack();
    chk("R12 cleared after ack", 64'(irq), 0);
  endtask

  task automatic t_enable();
    irq_en = 0;
    fill();
    pop("R11 pop masked");
    chk("R11 masked", 64'(irq), 0);
    @(negedge clk); irq_en = 1; #1;
    chk("R11 appears on enable", 64'(irq), 1);
    ack();
  endtask

  task automatic t_reserved();
    set_mode(2'd3);
    fill();
    for (int i = 0; i < D; i++) begin
      pop("R10 drain");
      chk("R10 never irq", 64'(irq), 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_half();
    t_full_whole();
    t_underrun();
    t_one();
    t_enable();
    t_reserved();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule